// File: doc/BRIEF.md
# I2C Register-Access Master Controller

This block is the single bus master for a two-wire serial bus. It runs complete register transactions against one slave device. A host gives it one command. The command names a 7-bit slave address, an 8-bit register index, a byte count and a direction. The controller then runs the whole sequence on the bus without further help from the host.

A write sends the addressed byte with the direction bit clear, then the register index, then the data bytes, then a stop. Each data byte is pulled from the host's `wr_data` input at the moment it is needed. A read writes the register index in the same way. It then issues a repeated start with no stop in between and addresses the slave again with the direction bit set. It then collects the requested bytes and presents each one on `rd_data` with a one-cycle `rd_valid` strobe.

Both bus lines are open-drain. Each line is modelled as a pull-down enable (`*_oe` high pulls the line low) plus the sampled level of the wire. A slave may hold SCL low to stretch the clock. The SCL half period is set by the parameter `HALF`, counted in system clocks, and must be at least 2.

Top module: `i2c_reg_master`

## Requirements
- R1: Out of reset and whenever no command is running, both `scl_oe` and `sda_oe` are 0 (lines released), and `busy` and `done` are 0.
- R2: A transaction opens with a start: SDA falls while SCL is high. It closes with a stop: SDA rises while SCL is high. Apart from start, repeated start and stop, SDA changes only while SCL is low, so a bus monitor sees no other start or stop.
- R3: A write puts these bytes on the bus, each MSB first with a 9th clock for the acknowledge: {addr,0}, the register index, then `cmd_len` data bytes, then a stop. `wr_take` pulses for one cycle after each data byte has been taken from `wr_data`, and the next byte must be on `wr_data` before it is needed.
- R4: A read puts these on the bus: {addr,0}, the register index, a repeated start with no stop before it, {addr,1}, then `cmd_len` bytes received MSB first, then a stop. Each received byte appears on `rd_data` with a one-cycle `rd_valid`.
- R5: During a read, the controller pulls SDA low in the 9th clock of every received byte except the last. For the last byte it leaves SDA released (NACK) before the stop.
- R6: If SDA reads high in the 9th clock of any byte the controller sent (either address byte, the register index or a data byte), it sends no further byte and issues a stop. `done` then comes with `err`=1. `err` stays valid until the next accepted command clears it.
- R7: A slave holding SCL low stalls the controller. The high phase is timed only from the first clock in which SCL reads high, so a stretched high phase lasts between `HALF`-1 and `HALF` clocks of observed high level, and the bytes are unaffected.
- R8: Without stretching, every SCL low phase and every SCL high phase inside a write lasts exactly `HALF` clocks.
- R9: `busy` is 1 from the cycle after a command is accepted until `done`. `done` is a one-cycle pulse with `busy` low. `cmd_valid` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a command when idle |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_addr | input | 7 | Slave address |
| cmd_reg | input | 8 | Register index |
| cmd_len | input | LEN_W | Number of data bytes (0 is taken as 1) |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Pulse after a write byte was taken |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | Pulse when `rd_data` is new |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Finished command saw a NACK |
| scl_oe | output | 1 | Pull SCL low |
| scl_i | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sampled SDA level |

## Verification
The bench targets the repeated start, the acknowledge policy on the last read byte, a NACK in the middle of the write data, and clock stretching.
- A controller that put a stop before the repeated start, or dropped the repeated start, would show up in the decoded event log.
- One that acknowledged the final byte would leave the slave driving into the stop.
- One that kept sending after a NACK, or failed to raise `err`, would log extra bytes or an error-free finish.
- A controller that timed the high phase from its own release of SCL instead of the observed level would produce short or missing high phases while a slave holds the line.

// File: rtl/i2c_reg_master.sv
`timescale 1ns/1ps
module i2c_reg_master #(
  parameter int HALF  = 10,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [6:0]       cmd_addr,
  input  logic [7:0]       cmd_reg,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             scl_oe,
  input  logic             scl_i,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam int CW = $clog2(HALF + 1);

  typedef enum logic [3:0] {S_IDLE, S_ST1, S_ST2, S_BLO, S_BHI, S_RS0, S_SP1, S_SP2, S_SP3} st_t;
  typedef enum logic [2:0] {K_AW, K_REG, K_WD, K_AR, K_RD} kind_t;

  st_t              st;
  kind_t            kind;
  logic [CW-1:0]    cnt;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [LEN_W-1:0] left;
  logic             rd_q;
  logic [6:0]       addr_q;
  logic [7:0]       reg_q;
  logic             scl_low, sda_low;

  wire tx        = (kind != K_RD);
  wire last      = (left == LEN_W'(1));
  wire half_done = (cnt == CW'(HALF - 1));

  assign scl_oe = scl_low;
  assign sda_oe = sda_low;
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_AW; cnt <= '0; bitn <= '0; sh <= '0; left <= '0;
      rd_q <= 1'b0; addr_q <= '0; reg_q <= '0; scl_low <= 1'b0; sda_low <= 1'b0;
      wr_take <= 1'b0; rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      wr_take <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (cmd_valid) begin
            rd_q   <= cmd_read;
            addr_q <= cmd_addr;
            reg_q  <= cmd_reg;
            left   <= (cmd_len == '0) ? LEN_W'(1) : cmd_len;
            err    <= 1'b0;
            kind   <= K_AW;
            sh     <= {cmd_addr, 1'b0};
            bitn   <= '0;
            st     <= S_ST1;
          end
        end
        S_ST1: if (scl_i) begin
          if (half_done) begin cnt <= '0; sda_low <= 1'b1; st <= S_ST2; end
          else cnt <= cnt + 1'b1;
        end
        S_ST2: begin
          if (half_done) begin cnt <= '0; scl_low <= 1'b1; st <= S_BLO; end
          else cnt <= cnt + 1'b1;
        end
        S_BLO: begin
          if (cnt == '0)
            sda_low <= (bitn == 4'd8) ? (!tx && !last) : (tx && !sh[7]);
          if (half_done) begin cnt <= '0; scl_low <= 1'b0; st <= S_BHI; end
          else cnt <= cnt + 1'b1;
        end
        S_BHI: if (scl_i) begin
          if (!half_done) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            scl_low <= 1'b1;
            if (bitn != 4'd8) begin
              sh   <= {sh[6:0], sda_i};
              bitn <= bitn + 4'd1;
              st   <= S_BLO;
            end else begin
              bitn <= '0;
              st   <= S_BLO;
              if (tx && sda_i) begin
                err <= 1'b1;
                st  <= S_SP1;
              end else begin
                case (kind)
                  K_AW: begin kind <= K_REG; sh <= reg_q; end
                  K_REG: begin
                    if (rd_q) begin kind <= K_AR; sh <= {addr_q, 1'b1}; st <= S_RS0; end
                    else begin kind <= K_WD; sh <= wr_data; wr_take <= 1'b1; end
                  end
                  K_WD: begin
                    if (last) st <= S_SP1;
                    else begin left <= left - 1'b1; sh <= wr_data; wr_take <= 1'b1; end
                  end
                  K_AR: kind <= K_RD;
                  default: begin
                    rd_data  <= sh;
                    rd_valid <= 1'b1;
                    if (last) st <= S_SP1;
                    else left <= left - 1'b1;
                  end
                endcase
              end
            end
          end
        end
        S_RS0: begin
          if (cnt == '0) sda_low <= 1'b0;
          if (half_done) begin cnt <= '0; scl_low <= 1'b0; st <= S_ST1; end
          else cnt <= cnt + 1'b1;
        end
        S_SP1: begin
          if (cnt == '0) sda_low <= 1'b1;
          if (half_done) begin cnt <= '0; scl_low <= 1'b0; st <= S_SP2; end
          else cnt <= cnt + 1'b1;
        end
        S_SP2: if (scl_i) begin
          if (half_done) begin cnt <= '0; sda_low <= 1'b0; st <= S_SP3; end
          else cnt <= cnt + 1'b1;
        end
        S_SP3: begin
          if (half_done) begin cnt <= '0; done <= 1'b1; st <= S_IDLE; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) |-> ($past(scl_low) || $past(st) == S_ST1 || $past(st) == S_SP2));

  p_take_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !rd_q);

  p_valid_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_q);

  p_ack_slot_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BLO && bitn == 4'd8 && kind != K_RD && cnt != '0) |-> !sda_oe);

  p_err_from_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(st) == S_BHI && $past(sda_i)));

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BHI && !scl_i) |=> $stable(cnt));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/i2c_reg_master_test.sv
`timescale 1ns/1ps
module i2c_reg_master_test;
  localparam int HALF = 6;
  localparam int LEN_W = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_read = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] cmd_reg = 0;
  logic [LEN_W-1:0] cmd_len = 0;
  logic [7:0] wr_data = 0;
  logic wr_take, rd_valid, busy, done, err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic slv_scl = 0, slv_sda = 0;
  logic scl_w, sda_w;

  assign scl_w = ~(scl_oe | slv_scl);
  assign sda_w = ~(sda_oe | slv_sda);

  always #5 clk = ~clk;

  i2c_reg_master #(.HALF(HALF), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_len(cmd_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .err(err), .scl_oe(scl_oe), .scl_i(scl_w), .sda_oe(sda_oe), .sda_i(sda_w));

  int nchk = 0, nfail = 0;
  int ev[32]; int nev = 0;
  int ex[32]; int nex = 0;
  logic [7:0] wr_arr[8];
  logic [7:0] rdmem[8];
  logic [7:0] rdq[8];
  int nrd = 0, ntake = 0, widx = 0;
  int wb = 0, nack_at = -1, rdi = 0, str_cyc = 0;
  int bc = 0;
  logic [7:0] rx = 0, txb = 0;
  logic rmode = 0, stx = 0, afirst = 0, lastack = 0;
  longint t_rise = 0, t_fall = 0;
  longint lo_min, lo_max, hi_min, hi_max;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    if (nev < 32) begin ev[nev] = v; nev++; end
  endtask

  task automatic add(input int v);
    ex[nex] = v; nex++;
  endtask

  task automatic check_log(input string req);
    check(nev == nex, {req, " event count"}, nev, nex);
    for (int i = 0; i < nex; i++) check(ev[i] == ex[i], req, ev[i], ex[i]);
  endtask

  // bus monitor and slave model: 256 start, 257 stop, 258 master ack, 259 master nack
  always @(negedge sda_w) if (scl_w === 1'b1) begin
    push(256); bc = 0; stx = 0; rmode = 0; afirst = 1;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) push(257);

  always @(posedge scl_w) begin
    t_rise = $time;
    if (t_fall > 0) begin
      if (t_rise - t_fall < lo_min) lo_min = t_rise - t_fall;
      if (t_rise - t_fall > lo_max) lo_max = t_rise - t_fall;
    end
    if (bc < 8) begin rx = {rx[6:0], sda_w}; bc++; end
    else if (bc == 8) begin
      if (stx) push(sda_w ? 259 : 258);
      lastack = !sda_w;
      bc = 9;
    end
  end

  always @(negedge scl_w) begin
    t_fall = $time;
    if (t_rise > 0) begin
      if (t_fall - t_rise < hi_min) hi_min = t_fall - t_rise;
      if (t_fall - t_rise > hi_max) hi_max = t_fall - t_rise;
    end
    #2;
    if (bc == 8) begin
      if (stx) slv_sda = 0;
      else begin
        push(int'(rx));
        slv_sda = (wb != nack_at);
        wb++;
        if (afirst) begin rmode = rx[0]; afirst = 0; end
      end
    end else if (bc == 9) begin
      bc = 0;
      slv_sda = 0;
      if (rmode && lastack) begin
        stx = 1; txb = rdmem[rdi]; rdi++; slv_sda = ~txb[7];
      end else stx = 0;
    end else if (stx && bc >= 1 && bc <= 7) slv_sda = ~txb[7-bc];
  end

  always @(negedge scl_w) if (str_cyc > 0) begin
    #1 slv_scl = 1;
    repeat (str_cyc) @(posedge clk);
    @(negedge clk);
    slv_scl = 0;
  end

  always @(negedge clk) begin
    if (wr_take) begin ntake++; widx++; wr_data = wr_arr[widx % 8]; end
    if (rd_valid) begin rdq[nrd % 8] = rd_data; nrd++; end
  end

  task automatic run_cmd(input bit rd, input logic [6:0] a, input logic [7:0] r, input int len,
                         input bit poke, output bit e);
    nev = 0; nex = 0; wb = 0; rdi = 0; nrd = 0; ntake = 0; widx = 0;
    t_rise = 0; t_fall = 0;
    lo_min = 1 << 30; lo_max = 0; hi_min = 1 << 30; hi_max = 0;
    @(negedge clk);
    wr_data = wr_arr[0];
    cmd_read = rd; cmd_addr = a; cmd_reg = r; cmd_len = LEN_W'(len); cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      cmd_addr = 7'h7F; cmd_read = ~rd; cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
    end
    while (!done) @(negedge clk);
    e = err;
    check(busy == 1'b0, "R9 busy low at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", done, 0);
    check(!scl_oe && !sda_oe, "R1 lines released after command", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_reset;
    check(!scl_oe && !sda_oe && !busy && !done, "R1 reset state", {scl_oe, sda_oe, busy, done}, 0);
  endtask

  task automatic t_write_two;
    bit e;
    wr_arr[0] = 8'hA5; wr_arr[1] = 8'h3C; nack_at = -1;
    run_cmd(0, 7'h2A, 8'h10, 2, 1, e);
    add(256); add(8'h54); add(8'h10); add(8'hA5); add(8'h3C); add(257);
    check_log("R3 R2 R9 write frame");
    check(e == 0, "R3 no error", e, 0);
    check(ntake == 2, "R3 wr_take count", ntake, 2);
    check(lo_min == HALF*10 && lo_max == HALF*10, "R8 SCL low phase", lo_max, HALF*10);
    check(hi_min == HALF*10 && hi_max == HALF*10, "R8 SCL high phase", hi_max, HALF*10);
    repeat (5) @(negedge clk);
    check(busy == 0, "R9 poke while busy ignored", busy, 0);
  endtask

  task automatic t_read_three;
    bit e;
    rdmem[0] = 8'h81; rdmem[1] = 8'hFE; rdmem[2] = 8'h5A; nack_at = -1;
    run_cmd(1, 7'h51, 8'h07, 3, 0, e);
    add(256); add(8'hA2); add(8'h07); add(256); add(8'hA3);
    add(258); add(258); add(259); add(257);
    check_log("R4 R5 read frame with repeated start");
    check(nrd == 3, "R4 rd_valid count", nrd, 3);
    check(rdq[0] == 8'h81, "R4 byte 0", rdq[0], 8'h81);
    check(rdq[1] == 8'hFE, "R4 byte 1", rdq[1], 8'hFE);
    check(rdq[2] == 8'h5A, "R4 byte 2", rdq[2], 8'h5A);
    check(e == 0 && ntake == 0, "R4 no error and no write take", {e, ntake[3:0]}, 0);
  endtask

  task automatic t_nack_addr;
    bit e;
    nack_at = 0;
    run_cmd(0, 7'h33, 8'h01, 2, 0, e);
    add(256); add(8'h66); add(257);
    check_log("R6 NACK on address");
    check(e == 1, "R6 err on address NACK", e, 1);
    check(ntake == 0, "R6 no data taken", ntake, 0);
  endtask

  task automatic t_recover;
    bit e;
    wr_arr[0] = 8'h99; nack_at = -1;
    run_cmd(0, 7'h33, 8'h00, 1, 0, e);
    add(256); add(8'h66); add(8'h00); add(8'h99); add(257);
    check_log("R3 single byte write");
    check(e == 0, "R6 err cleared by next command", e, 0);
  endtask

  task automatic t_nack_data;
    bit e;
    wr_arr[0] = 8'h11; wr_arr[1] = 8'h22; wr_arr[2] = 8'h33; nack_at = 3;
    run_cmd(0, 7'h0F, 8'h40, 3, 0, e);
    add(256); add(8'h1E); add(8'h40); add(8'h11); add(8'h22); add(257);
    check_log("R6 NACK on second data byte");
    check(e == 1, "R6 err on data NACK", e, 1);
    check(ntake == 2, "R6 no take after NACK", ntake, 2);
  endtask

  task automatic t_stretch;
    bit e;
    wr_arr[0] = 8'hC3; nack_at = -1; str_cyc = 30;
    run_cmd(0, 7'h12, 8'h34, 1, 0, e);
    str_cyc = 0;
    add(256); add(8'h24); add(8'h34); add(8'hC3); add(257);
    check_log("R7 write under stretching");
    check(e == 0, "R7 no error", e, 0);
    check(lo_min >= 300, "R7 low phase held by slave", lo_min, 300);
    check(hi_min >= (HALF-1)*10 && hi_max <= HALF*10, "R7 high phase timed after release",
          hi_min, (HALF-1)*10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_two;
    t_read_three;
    t_nack_addr;
    t_recover;
    t_nack_data;
    t_stretch;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule